// File: doc/BRIEF.md
# Row-Scanning Reference-ID Search Memory

This block stores the non-root entries of a k-ary timer heap, with one memory row holding k entries side by side. Every entry carries a cyclic priority, a normal priority and a reference ID. The heap engine uses an ordinary synchronous port to read whole rows and to write them. A per-entry write mask lets it change single entries in a row without touching the others. The root entry is not kept here. The controller holds it in a register of its own.

To find where an entry lives, the engine issues a search command with a reference ID and the current number of stored entries. The block then reads one row per cycle and compares all k IDs of that row at once. It stops at the first row that holds a match. It returns the flat heap index of the entry, or a not-found result once the valid rows are used up. While a search runs, `busy` is high and the normal port is locked out.

Top module: `heap_id_search_mem`

## Requirements
- R1: After reset, `busy`, `done` and `found` are low and `match_idx` is zero.
- R2: When the block is idle and `srch_start` is low, a read (`mem_en`=1, `mem_we`=0) of row A puts that row on `mem_rdata` after the next rising edge. Entry s of a row occupies bits [s*EW +: EW]. Inside an entry, the ID is in the low `ID_W` bits, the normal priority sits above it, and the cyclic priority is in the top bits.
- R3: Under the same conditions, a write with `mem_wmask` updates exactly those entries of the row whose mask bit is 1. Every other entry keeps its value.
- R4: `srch_start` while idle makes `busy` rise after that edge. `busy` stays high until the edge at which `done` rises, and then falls on that same edge.
- R5: On a hit in row r, slot s, the block shows `done`=1, `found`=1 and `match_idx`=r*k+s+1 exactly r+2 edges after the start edge.
- R6: When several slots in the first matching row hold the searched ID, the lowest slot wins.
- R7: An entry whose flat position r*k+s is not below the captured `elem_cnt` never matches. This includes the unused tail of a partial last row. A reported index lies in 1..`elem_cnt`.
- R8: With no valid match, `done`=1, `found`=0 and `match_idx`=0 appear ceil(`elem_cnt`/k)+1 edges after the start edge. With a count of zero this is one edge.
- R9: While busy, `mem_en` requests are ignored, so no write lands. A `srch_start` in the same cycle as an idle-state `mem_en` wins, and the access is dropped.
- R10: `done` is high for one cycle only. A `srch_start` in a cycle where `busy` is high, including the cycle of the last busy edge, is ignored. `found` and `match_idx` hold until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | input | 1 | Row access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | clog2(ROWS) | Row address |
| mem_wmask | input | ELEMS_PER_ROW | Per-entry write enable |
| mem_wdata | input | ELEMS_PER_ROW*EW | Row write data |
| mem_rdata | output | ELEMS_PER_ROW*EW | Registered row read data |
| srch_start | input | 1 | Start a search |
| srch_id | input | ID_W | Reference ID to find |
| elem_cnt | input | clog2(ROWS*ELEMS_PER_ROW+1) | Number of stored non-root entries |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| found | output | 1 | Last search hit |
| match_idx | output | clog2(ROWS*ELEMS_PER_ROW+1) | Flat heap index of the hit, 0 on miss |

## Verification
Some properties are checked on every cycle. `busy` only rises after a start request. `done` ends `busy` and lasts a single cycle. A miss reports index zero, and a hit reports an index inside the captured count. Other behaviours only show through the bench's scenarios against its behavioural model:
- the exact search latency for hits and misses;
- lowest-slot priority among duplicate IDs;
- exclusion of slots past a partial count;
- masked writes;
- writes and restarts being dropped while busy.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  typedef enum logic {ST_IDLE, ST_SCAN} scan_state_t;
endpackage

// File: rtl/hsm_row_ram.sv
module hsm_row_ram #(
  parameter int K     = 4,
  parameter int DEPTH = 8,
  parameter int EW    = 18,
  localparam int ROW_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              en,
  input  logic [K-1:0]      we,
  input  logic [ROW_W-1:0]  addr,
  input  logic [K*EW-1:0]   wdata,
  output logic [K*EW-1:0]   q
);
  // one narrow array per slot so the mask maps to independent write enables
  for (genvar s = 0; s < K; s++) begin : g_slot
    logic [EW-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (en) begin
        if (we[s]) store[addr] <= wdata[s*EW +: EW];
        q[s*EW +: EW] <= store[addr];
      end
    end
  end
endmodule

// File: rtl/hsm_row_match.sv
module hsm_row_match #(
  parameter int K     = 4,
  parameter int DEPTH = 8,
  parameter int ID_W  = 6,
  localparam int IDX_W  = $clog2(DEPTH*K+1),
  localparam int SLOT_W = (K > 1) ? $clog2(K) : 1
) (
  input  logic [K*ID_W-1:0]  ids_i,
  input  logic [ID_W-1:0]    key_i,
  input  logic [IDX_W-1:0]   base_i,
  input  logic [IDX_W-1:0]   limit_i,
  output logic               hit_o,
  output logic [SLOT_W-1:0]  slot_o
);
  logic [K-1:0] eq;

  for (genvar s = 0; s < K; s++) begin : g_cmp
    logic in_range;
    assign in_range = ({1'b0, base_i} + (IDX_W+1)'(s)) < {1'b0, limit_i};
    assign eq[s]    = in_range && (ids_i[s*ID_W +: ID_W] == key_i);
  end

  always_comb begin
    slot_o = '0;
    for (int s = K-1; s >= 0; s--) begin
      if (eq[s]) slot_o = SLOT_W'(s);
    end
    hit_o = |eq;
  end
endmodule

// File: rtl/hsm_scan_ctrl.sv
module hsm_scan_ctrl
  import hsm_pkg::*;
#(
  parameter int K     = 4,
  parameter int DEPTH = 8,
  parameter int ID_W  = 6,
  localparam int ROW_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int IDX_W  = $clog2(DEPTH*K+1),
  localparam int SLOT_W = (K > 1) ? $clog2(K) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [ID_W-1:0]    key_i,
  input  logic [IDX_W-1:0]   cnt_i,
  input  logic               hit_i,
  input  logic [SLOT_W-1:0]  slot_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               found_o,
  output logic [IDX_W-1:0]   index_o,
  output logic               rd_en_o,
  output logic [ROW_W-1:0]   rd_row_o,
  output logic [ID_W-1:0]    key_o,
  output logic [IDX_W-1:0]   limit_o,
  output logic [IDX_W-1:0]   cmp_base_o
);
  scan_state_t       state;
  logic [ROW_W-1:0]  issue_row;
  logic [IDX_W-1:0]  issue_base;
  logic              cmp_vld;
  logic [IDX_W-1:0]  cmp_base;
  logic [ID_W-1:0]   key;
  logic [IDX_W-1:0]  limit;
  logic              done, found;
  logic [IDX_W-1:0]  index;
  logic              more_rows;
  logic [IDX_W-1:0]  hit_idx;

  assign more_rows = issue_base < limit;
  assign hit_idx   = cmp_base + IDX_W'(slot_i) + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      issue_row  <= '0;
      issue_base <= '0;
      cmp_vld    <= 1'b0;
      cmp_base   <= '0;
      key        <= '0;
      limit      <= '0;
      done       <= 1'b0;
      found      <= 1'b0;
      index      <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state      <= ST_SCAN;
            key        <= key_i;
            limit      <= cnt_i;
            issue_row  <= '0;
            issue_base <= '0;
            cmp_vld    <= 1'b0;
          end
        end
        default: begin
          if (cmp_vld && hit_i) begin
            state   <= ST_IDLE;
            done    <= 1'b1;
            found   <= 1'b1;
            index   <= hit_idx;
            cmp_vld <= 1'b0;
          end else if (!more_rows) begin
            state   <= ST_IDLE;
            done    <= 1'b1;
            found   <= 1'b0;
            index   <= '0;
            cmp_vld <= 1'b0;
          end else begin
            cmp_vld    <= 1'b1;
            cmp_base   <= issue_base;
            issue_row  <= issue_row + ROW_W'(1);
            issue_base <= issue_base + IDX_W'(K);
          end
        end
      endcase
    end
  end

  assign busy_o     = (state == ST_SCAN);
  assign done_o     = done;
  assign found_o    = found;
  assign index_o    = index;
  assign rd_en_o    = (state == ST_SCAN) && more_rows;
  assign rd_row_o   = issue_row;
  assign key_o      = key;
  assign limit_o    = limit;
  assign cmp_base_o = cmp_base;

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i)); // R4
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o))); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10
  AST_MISS_ZERO_IDX: assert property (@(posedge clk) disable iff (rst)
    (done_o && !found_o) |-> (index_o == '0)); // R8
  AST_HIT_IN_COUNT: assert property (@(posedge clk) disable iff (rst)
    (done_o && found_o) |-> (index_o != '0 && index_o <= limit_o)); // R7
endmodule

// File: rtl/heap_id_search_mem.sv
module heap_id_search_mem #(
  parameter int ELEMS_PER_ROW = 4,
  parameter int ROWS          = 8,
  parameter int CPRIO_W       = 4,
  parameter int NPRIO_W       = 8,
  parameter int ID_W          = 6
) (
  input  logic                                               clk,
  input  logic                                               rst,
  input  logic                                               mem_en,
  input  logic                                               mem_we,
  input  logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0]         mem_addr,
  input  logic [ELEMS_PER_ROW-1:0]                           mem_wmask,
  input  logic [ELEMS_PER_ROW*(CPRIO_W+NPRIO_W+ID_W)-1:0]    mem_wdata,
  output logic [ELEMS_PER_ROW*(CPRIO_W+NPRIO_W+ID_W)-1:0]    mem_rdata,
  input  logic                                               srch_start,
  input  logic [ID_W-1:0]                                    srch_id,
  input  logic [$clog2(ROWS*ELEMS_PER_ROW+1)-1:0]            elem_cnt,
  output logic                                               busy,
  output logic                                               done,
  output logic                                               found,
  output logic [$clog2(ROWS*ELEMS_PER_ROW+1)-1:0]            match_idx
);
  localparam int K      = ELEMS_PER_ROW;
  localparam int EW     = CPRIO_W + NPRIO_W + ID_W;
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int IDX_W  = $clog2(ROWS*K+1);
  localparam int SLOT_W = (K > 1) ? $clog2(K) : 1;

  logic              acc_ok;
  logic              scan_en;
  logic [ROW_W-1:0]  scan_row;
  logic              ram_en;
  logic [K-1:0]      ram_we;
  logic [ROW_W-1:0]  ram_addr;
  logic [K*EW-1:0]   ram_q;
  logic [K*ID_W-1:0] row_ids;
  logic [ID_W-1:0]   key;
  logic [IDX_W-1:0]  limit;
  logic [IDX_W-1:0]  cmp_base;
  logic              hit;
  logic [SLOT_W-1:0] slot;

  // a search request in the same cycle takes priority over port access
  assign acc_ok   = !busy && !srch_start && mem_en;
  assign ram_en   = busy ? scan_en : acc_ok;
  assign ram_addr = busy ? scan_row : mem_addr;
  assign ram_we   = {K{acc_ok && mem_we}} & mem_wmask;

  for (genvar s = 0; s < K; s++) begin : g_ids
    assign row_ids[s*ID_W +: ID_W] = ram_q[s*EW +: ID_W];
  end

  hsm_row_ram #(.K(K), .DEPTH(ROWS), .EW(EW)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (mem_wdata),
    .q     (ram_q)
  );

  hsm_row_match #(.K(K), .DEPTH(ROWS), .ID_W(ID_W)) u_match (
    .ids_i   (row_ids),
    .key_i   (key),
    .base_i  (cmp_base),
    .limit_i (limit),
    .hit_o   (hit),
    .slot_o  (slot)
  );

  hsm_scan_ctrl #(.K(K), .DEPTH(ROWS), .ID_W(ID_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (srch_start),
    .key_i      (srch_id),
    .cnt_i      (elem_cnt),
    .hit_i      (hit),
    .slot_i     (slot),
    .busy_o     (busy),
    .done_o     (done),
    .found_o    (found),
    .index_o    (match_idx),
    .rd_en_o    (scan_en),
    .rd_row_o   (scan_row),
    .key_o      (key),
    .limit_o    (limit),
    .cmp_base_o (cmp_base)
  );

  assign mem_rdata = ram_q;

  AST_NO_PORT_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> (ram_we == '0)); // R9
endmodule

// File: tb/sim_heap_id_search_mem.sv
module sim_heap_id_search_mem;
  localparam int K   = 4;
  localparam int D   = 8;
  localparam int CW  = 4;
  localparam int NW  = 8;
  localparam int IDW = 6;
  localparam int EW  = CW + NW + IDW;
  localparam int RW  = $clog2(D);
  localparam int IW  = $clog2(D*K+1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_en = 1'b0, mem_we = 1'b0;
  logic [RW-1:0] mem_addr = '0;
  logic [K-1:0] mem_wmask = '0;
  logic [K*EW-1:0] mem_wdata = '0;
  logic [K*EW-1:0] mem_rdata;
  logic srch_start = 1'b0;
  logic [IDW-1:0] srch_id = '0;
  logic [IW-1:0] elem_cnt = '0;
  logic busy, done, found;
  logic [IW-1:0] match_idx;

  always #10 clk = ~clk;

  heap_id_search_mem #(.ELEMS_PER_ROW(K), .ROWS(D), .CPRIO_W(CW), .NPRIO_W(NW), .ID_W(IDW)) u0 (
    .clk(clk), .rst(rst), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wmask(mem_wmask), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .srch_start(srch_start), .srch_id(srch_id), .elem_cnt(elem_cnt),
    .busy(busy), .done(done), .found(found), .match_idx(match_idx));

  // behavioural model
  logic [EW-1:0] mdl [D*K];
  bit m_busy, m_done, m_found, m_rd_chk;
  int m_left, m_res_idx, m_idx;
  bit m_res_found;
  logic [K*EW-1:0] m_rd_exp;
  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  function automatic logic [EW-1:0] mk(int cyc, int nrm, int id);
    return {CW'(cyc), NW'(nrm), IDW'(id)};
  endfunction

  task automatic mdl_edge();
    if (rst) begin
      m_busy = 0; m_done = 0; m_found = 0; m_idx = 0; m_rd_chk = 0;
    end else begin
      m_done = 0; m_rd_chk = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_found = m_res_found; m_idx = m_res_idx;
        end
      end else if (srch_start) begin
        int hitf = -1;
        for (int f = 0; f < int'(elem_cnt); f++)
          if (hitf < 0 && mdl[f][IDW-1:0] == srch_id) hitf = f;
        m_res_found = (hitf >= 0);
        m_res_idx = m_res_found ? hitf + 1 : 0;
        m_left = m_res_found ? hitf / K + 2 : (int'(elem_cnt) + K - 1) / K + 1;
        m_busy = 1;
      end else if (mem_en) begin
        if (mem_we) begin
          for (int s = 0; s < K; s++)
            if (mem_wmask[s]) mdl[int'(mem_addr)*K + s] = mem_wdata[s*EW +: EW];
        end else begin
          m_rd_chk = 1;
          for (int s = 0; s < K; s++) m_rd_exp[s*EW +: EW] = mdl[int'(mem_addr)*K + s];
        end
      end
    end
  endtask

  task automatic chk(string what, logic [K*EW-1:0] act, logic [K*EW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("busy", (K*EW)'(busy), (K*EW)'(m_busy));
    chk("done", (K*EW)'(done), (K*EW)'(m_done));
    chk("found", (K*EW)'(found), (K*EW)'(m_found));
    chk("match_idx", (K*EW)'(match_idx), (K*EW)'(m_idx));
    if (m_rd_chk) chk("mem_rdata", mem_rdata, m_rd_exp);
  endtask

  task automatic cyc();
    @(posedge clk);
    mdl_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(int row, logic [K-1:0] mask, logic [K*EW-1:0] data);
    mem_en = 1; mem_we = 1; mem_addr = RW'(row); mem_wmask = mask; mem_wdata = data;
    cyc();
    mem_en = 0; mem_we = 0; mem_wmask = '0;
  endtask

  task automatic rd(int row);
    mem_en = 1; mem_we = 0; mem_addr = RW'(row);
    cyc();
    mem_en = 0;
  endtask

  task automatic search(int id, int cnt);
    srch_start = 1; srch_id = IDW'(id); elem_cnt = IW'(cnt);
    cyc();
    srch_start = 0;
    while (m_busy) cyc();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog expired actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [K*EW-1:0] row;
    @(negedge clk);
    cur_req = "R1";
    repeat (3) cyc();
    rst = 0;
    cyc();

    cur_req = "R2";
    for (int r = 0; r < D; r++) begin
      for (int s = 0; s < K; s++) row[s*EW +: EW] = mk(r*K+s, (r*K+s)*3+1, r*K+s+10);
      wr(r, '1, row);
    end
    rd(0); rd(5); rd(7);

    cur_req = "R3";
    for (int s = 0; s < K; s++) row[s*EW +: EW] = mk(15, 200+s, 60+s/2);
    wr(2, 4'b0101, row);
    rd(2);
    search(18, 32);
    search(61, 32);

    cur_req = "R5";
    search(10, 32);
    search(41, 32);
    search(27, 32);

    cur_req = "R6";
    for (int s = 0; s < K; s++) row[s*EW +: EW] = mk(1, 2, 50);
    wr(3, 4'b1010, row);
    rd(3);
    search(50, 32);

    cur_req = "R7";
    search(50, 14);
    search(50, 13);
    search(41, 31);

    cur_req = "R8";
    search(10, 0);
    search(63, 32);

    cur_req = "R9";
    srch_start = 1; srch_id = IDW'(41); elem_cnt = IW'(32);
    cyc();
    srch_start = 0;
    cyc();
    for (int s = 0; s < K; s++) row[s*EW +: EW] = mk(9, 9, 9);
    mem_en = 1; mem_we = 1; mem_addr = '0; mem_wmask = '1; mem_wdata = row;
    srch_start = 1; srch_id = IDW'(10);
    cyc(); cyc();
    mem_en = 0; mem_we = 0; srch_start = 0;
    while (m_busy) cyc();
    rd(0);
    srch_start = 1; srch_id = IDW'(11); elem_cnt = IW'(32);
    mem_en = 1; mem_we = 1; mem_addr = RW'(1); mem_wmask = '1;
    cyc();
    srch_start = 0; mem_en = 0; mem_we = 0;
    while (m_busy) cyc();
    rd(1);

    cur_req = "R10";
    srch_start = 1; srch_id = IDW'(12); elem_cnt = IW'(32);
    cyc();
    srch_start = 0;
    while (m_busy) begin
      if (m_left == 1) begin srch_start = 1; srch_id = IDW'(20); end
      cyc();
    end
    srch_start = 0;
    cyc(); cyc();
    search(12, 32);
    cyc();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule